// File: doc/BRIEF.md
# Caption Line Strobe Timer

This block follows the line structure of a video field in the digital domain. It counts line ticks from the start of each field and records whether the field is odd or even. It raises a strobe for the whole of the one line that carries caption data. A 2-bit mode input chooses three things: which line gets the strobe, whether both fields or only even fields are served, and where line timing comes from. Line timing is either a synchronous hsync pulse or an oscillator enable divided down to line rate.

A caption-data consumer watches `cap_pulse`. Its falling edge marks the end of the caption line. At that moment `field_odd` is still valid and tells which field the data belongs to. The mode encoding on `mode` is {bit1, bit0}:
- 00: 525-line recorder timing, driven from hsync.
- 01: the same recorder timing, with line timing taken from the oscillator divider.
- 10: 525-line receiver timing.
- 11: 625-line receiver timing.

None of the pins carry data words, so there is no handshake and no back-pressure. All outputs are plain levels or one-cycle strobes that the consumer samples when it chooses.

Top module: `capline_timer`

## Requirements
- R1: In modes 00 and 01, `cap_pulse` is raised only for line 21, and only in fields whose latched parity is even (`field_hint` low at the field's first line tick).
- R2: In mode 10, `cap_pulse` is raised for line 21 of every field, odd or even.
- R3: In mode 11, `cap_pulse` is raised for line 22 of every field, odd or even.
- R4: `cap_pulse` rises on the clock edge that samples the line tick starting the target line. It falls on the edge that samples the next line tick, so it is high for exactly one line and at most once per field.
- R5: The first line tick after a `vsync` pulse sets the line number to 1 and latches `field_hint` as the field parity (1 = odd). A `vsync` sampled in the same cycle as a line tick takes effect at the following tick.
- R6: In modes 00, 10 and 11, `field_odd` shows the latched parity and changes only at a line-1 tick, so it is stable throughout the strobe. In mode 01 it is held low.
- R7: In mode 01, `line_ref` is a one-cycle pulse in the cycle after every OSC_DIV-th sampled `osc_tick` (OSC_DIV defaults to 32). `hsync` has no effect on it.
- R8: In modes 00, 10 and 11, `line_ref` is high in exactly the cycles where an accepted `hsync` is present.
- R9: An `hsync` that comes fewer than MIN_GAP cycles after the previous accepted line tick is ignored. This covers equalising pulses and pulses held for more than one cycle.
- R10: After reset, all outputs are low. No strobe appears until a field start has been seen.
- R11: The line number saturates at 2^LINE_W-1 and does not wrap, so a very long field produces no second strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Operating mode {bit1, bit0} |
| hsync | input | 1 | Synchronous horizontal sync pulse |
| vsync | input | 1 | Field start pulse |
| field_hint | input | 1 | Field parity hint, 1 = odd |
| osc_tick | input | 1 | Oscillator enable, one cycle per oscillator period |
| cap_pulse | output | 1 | Caption line strobe |
| field_odd | output | 1 | Latched field parity |
| line_ref | output | 1 | Line-rate reference tick |

## Verification
The bench targets the following corner cases:
- Equalising pulses at half-line spacing and vsync landing on an hsync cycle. A design that accepts the early pulses, or resets on the coincident tick, strobes the wrong line.
- A parity hint that toggles mid-field. A design that re-samples it would flip `field_odd` in the middle of a strobe.
- A field longer than the counter range. A wrapping counter would strobe a second time.
- Mode 01 with random oscillator enables and stray hsync. Here the divide count and the suppression of hsync are both checked.

// File: rtl/capline_pkg.sv
package capline_pkg;

  typedef enum logic [1:0] {
    CM_REC_HS  = 2'b00,
    CM_REC_OSC = 2'b01,
    CM_RX_525  = 2'b10,
    CM_RX_625  = 2'b11
  } cap_mode_e;

  function automatic logic mode_uses_osc(cap_mode_e m);
    return m == CM_REC_OSC;
  endfunction

  function automatic logic mode_both_fields(cap_mode_e m);
    return (m == CM_RX_525) || (m == CM_RX_625);
  endfunction

  function automatic logic mode_late_line(cap_mode_e m);
    return m == CM_RX_625;
  endfunction

endpackage

// File: rtl/capline_ref_src.sv
module capline_ref_src #(
  parameter int MIN_GAP = 1600,
  parameter int OSC_DIV = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic use_osc,
  input  logic hsync,
  input  logic osc_tick,
  output logic line_tick
);
  localparam int GAP_W = (MIN_GAP > 2) ? $clog2(MIN_GAP) : 1;
  localparam logic [GAP_W-1:0] GAP_SAT = GAP_W'(MIN_GAP - 1);

  logic             div_tick;
  logic [GAP_W-1:0] gap_cnt;
  logic             hs_ok;

  generate
    if (OSC_DIV > 1) begin : g_div
      localparam int DIV_W = $clog2(OSC_DIV);
      localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(OSC_DIV - 1);
      logic [DIV_W-1:0] div_cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) begin
          div_cnt  <= '0;
          div_tick <= 1'b0;
        end else begin
          div_tick <= osc_tick && (div_cnt == DIV_LAST);
          if (osc_tick) div_cnt <= (div_cnt == DIV_LAST) ? '0 : div_cnt + 1'b1;
        end
      end
    end else begin : g_nodiv
      always_ff @(posedge clk) begin
        if (!rst_n) div_tick <= 1'b0;
        else        div_tick <= osc_tick;
      end
    end
  endgenerate

  assign hs_ok     = hsync && (gap_cnt == GAP_SAT);
  assign line_tick = use_osc ? div_tick : hs_ok;

  always_ff @(posedge clk) begin
    if (!rst_n)                gap_cnt <= GAP_SAT;
    else if (line_tick)        gap_cnt <= '0;
    else if (gap_cnt != GAP_SAT) gap_cnt <= gap_cnt + 1'b1;
  end
endmodule

// File: rtl/capline_counter.sv
module capline_counter #(
  parameter int LINE_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              line_tick,
  input  logic              vsync,
  input  logic              field_hint,
  output logic [LINE_W-1:0] cnt_nx,
  output logic              fld_nx,
  output logic              seen_nx,
  output logic              fld_q,
  output logic              seen_q
);
  localparam logic [LINE_W-1:0] LMAX = '1;

  logic [LINE_W-1:0] cnt_q;
  logic              pend_q;

  always_comb begin
    cnt_nx  = cnt_q;
    fld_nx  = fld_q;
    seen_nx = seen_q;
    if (line_tick) begin
      if (pend_q) begin
        cnt_nx  = LINE_W'(1);
        fld_nx  = field_hint;
        seen_nx = 1'b1;
      end else if (cnt_q != LMAX) begin
        cnt_nx = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      fld_q  <= 1'b0;
      seen_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_nx;
      fld_q  <= fld_nx;
      seen_q <= seen_nx;
      pend_q <= vsync | (pend_q & ~line_tick);
    end
  end
endmodule

// File: rtl/capline_strobe.sv
module capline_strobe
  import capline_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int LINE_525 = 21,
  parameter int LINE_625 = 22
) (
  input  logic              clk,
  input  logic              rst_n,
  input  cap_mode_e         mode,
  input  logic              line_tick,
  input  logic [LINE_W-1:0] cnt_nx,
  input  logic              fld_nx,
  input  logic              seen_nx,
  output logic              cap_pulse
);
  localparam logic [LINE_W-1:0] T525 = LINE_W'(LINE_525);
  localparam logic [LINE_W-1:0] T625 = LINE_W'(LINE_625);

  logic [LINE_W-1:0] target;
  logic              hit;

  assign target = mode_late_line(mode) ? T625 : T525;
  assign hit    = seen_nx && (cnt_nx == target) && (mode_both_fields(mode) || !fld_nx);

  always_ff @(posedge clk) begin
    if (!rst_n)         cap_pulse <= 1'b0;
    else if (line_tick) cap_pulse <= hit;
  end
endmodule

// File: rtl/capline_timer.sv
module capline_timer
  import capline_pkg::*;
#(
  parameter int LINE_W   = 10,
  parameter int MIN_GAP  = 1600,
  parameter int OSC_DIV  = 32,
  parameter int LINE_525 = 21,
  parameter int LINE_625 = 22
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] mode,
  input  logic       hsync,
  input  logic       vsync,
  input  logic       field_hint,
  input  logic       osc_tick,
  output logic       cap_pulse,
  output logic       field_odd,
  output logic       line_ref
);
  cap_mode_e         mode_e;
  logic              line_tick;
  logic [LINE_W-1:0] cnt_nx;
  logic              fld_nx;
  logic              seen_nx;
  logic              fld_q;
  logic              seen_q;

  assign mode_e = cap_mode_e'(mode);

  capline_ref_src #(.MIN_GAP(MIN_GAP), .OSC_DIV(OSC_DIV)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .use_osc  (mode_uses_osc(mode_e)),
    .hsync    (hsync),
    .osc_tick (osc_tick),
    .line_tick(line_tick)
  );

  capline_counter #(.LINE_W(LINE_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .line_tick (line_tick),
    .vsync     (vsync),
    .field_hint(field_hint),
    .cnt_nx    (cnt_nx),
    .fld_nx    (fld_nx),
    .seen_nx   (seen_nx),
    .fld_q     (fld_q),
    .seen_q    (seen_q)
  );

  capline_strobe #(.LINE_W(LINE_W), .LINE_525(LINE_525), .LINE_625(LINE_625)) u_stb (
    .clk      (clk),
    .rst_n    (rst_n),
    .mode     (mode_e),
    .line_tick(line_tick),
    .cnt_nx   (cnt_nx),
    .fld_nx   (fld_nx),
    .seen_nx  (seen_nx),
    .cap_pulse(cap_pulse)
  );

  assign field_odd = mode_uses_osc(mode_e) ? 1'b0 : fld_q;
  assign line_ref  = line_tick;
endmodule

// File: rtl/capline_timer_chk.sv
module capline_timer_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [1:0] mode,
  input logic       hsync,
  input logic       line_ref,
  input logic       cap_pulse,
  input logic       field_odd,
  input logic       fld_q,
  input logic       seen_q
);
  // R4: the strobe only changes on the edge that sampled a line tick
  a_r4_edge_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse != $past(cap_pulse)) |-> $past(line_ref));

  // R6: field level steady while the strobe is held
  a_r6_field_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_pulse && $past(cap_pulse) && $stable(mode)) |-> $stable(field_odd));

  // R1: recorder modes strobe only in even fields
  a_r1_even_only: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(cap_pulse) && !$past(mode[1])) |-> !fld_q);

  // R8: outside mode 01 a reference tick needs hsync present
  a_r8_ref_from_hs: assert property (@(posedge clk) disable iff (!rst_n)
    (line_ref && (mode != 2'b01)) |-> hsync);

  // R7: divided reference lasts a single cycle
  a_r7_ref_single: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_ref) && (mode == 2'b01) && ($past(mode) == 2'b01)) |-> !line_ref);

  // R10: no strobe before the first field start
  a_r10_no_early: assert property (@(posedge clk) disable iff (!rst_n)
    !seen_q |-> !cap_pulse);
endmodule

bind capline_timer capline_timer_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .mode     (mode),
  .hsync    (hsync),
  .line_ref (line_ref),
  .cap_pulse(cap_pulse),
  .field_odd(field_odd),
  .fld_q    (fld_q),
  .seen_q   (seen_q)
);

// File: tb/capline_timer_test.sv
`timescale 1ns/1ps
module capline_timer_test;
  localparam int LW   = 5;
  localparam int GAP  = 8;
  localparam int DIV  = 32;
  localparam int LMAX = (1 << LW) - 1;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'b00;
  logic       hsync = 1'b0, vsync = 1'b0, field_hint = 1'b0, osc_tick = 1'b0;
  logic       cap_pulse, field_odd, line_ref;

  int n_run = 0, n_fail = 0;
  int m_line = 0, m_gap = GAP, m_osc = 0;
  bit m_seen = 0, m_odd = 0, m_pend = 0, m_div = 0, m_cap = 0;
  int act_rise = 0, exp_rise = 0;
  bit prev_act = 0;

  always #2 clk = ~clk;

  capline_timer #(.LINE_W(LW), .MIN_GAP(GAP), .OSC_DIV(DIV)) uut (
    .clk(clk), .rst_n(rst_n), .mode(mode), .hsync(hsync), .vsync(vsync),
    .field_hint(field_hint), .osc_tick(osc_tick),
    .cap_pulse(cap_pulse), .field_odd(field_odd), .line_ref(line_ref));

  task automatic check(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int target_line(input logic [1:0] m);
    return (m == 2'b11) ? 22 : 21;
  endfunction

  function automatic string cap_tag(input logic [1:0] m);
    if (!m_seen) return "R10";
    if (m_line == LMAX) return "R11";
    if (m == 2'b10) return "R2";
    if (m == 2'b11) return "R3";
    return "R1";
  endfunction

  task automatic step(input bit hs, input bit vs, input bit hint, input bit osc);
    bit tick, hit;
    @(negedge clk);
    hsync = hs; vsync = vs; field_hint = hint; osc_tick = osc;
    #1;
    tick = (mode == 2'b01) ? m_div : (hs && m_gap >= GAP);
    if (hs && !tick && mode != 2'b01) check("R9", line_ref, tick);
    else if (mode == 2'b01)           check("R7", line_ref, tick);
    else                              check("R8", line_ref, tick);
    check(cap_tag(mode), cap_pulse, m_cap);
    check("R6", field_odd, (mode == 2'b01) ? 0 : m_odd);
    if (cap_pulse && !prev_act) act_rise++;
    prev_act = cap_pulse;
    if (tick) begin
      if (m_pend) begin m_line = 1; m_odd = hint; m_seen = 1; end
      else if (m_line < LMAX) m_line++;
      hit = m_seen && m_line == target_line(mode) && (mode[1] || !m_odd);
      if (hit && !m_cap) exp_rise++;
      m_cap = hit;
    end
    m_pend = vs | (m_pend & ~tick);
    m_gap  = tick ? 1 : ((m_gap < GAP) ? m_gap + 1 : GAP);
    m_div  = osc && (m_osc == DIV - 1);
    if (osc) m_osc = (m_osc + 1) % DIV;
  endtask

  // one field of hsync-driven lines
  task automatic field_scn(input int nl, input bit hint, input bit eq, input bit vs_on_hs);
    int g;
    act_rise = 0; exp_rise = 0;
    if (vs_on_hs) begin
      for (int c = 0; c < GAP - 1; c++) step(0, 0, $urandom % 2, $urandom % 2);
      step(1, 1, ~hint, 0);  // R5: coincident vsync, reset deferred
    end else begin
      step(0, 1, $urandom % 2, 0);
    end
    for (int l = 1; l <= nl; l++) begin
      g = GAP + ($urandom % 7);
      for (int c = 0; c < g; c++) begin
        bit last, hs;
        last = (c == g - 1);
        hs = last || (eq && l >= 2 && l < 10 && c == g / 2);
        step(hs, 0, (l == 1 && last) ? hint : bit'($urandom % 2), $urandom % 2);
      end
      if (l == 1) begin
        step(0, 0, $urandom % 2, 0);
        check("R5", field_odd, (mode == 2'b01) ? 0 : hint);
      end
    end
    check("R4", act_rise, exp_rise);
  endtask

  // oscillator-driven field; hsync is noise here
  task automatic osc_scn(input int ncyc);
    act_rise = 0; exp_rise = 0;
    step(0, 1, $urandom % 2, 1);
    for (int i = 0; i < ncyc; i++)
      step(($urandom % 5) == 0, 0, $urandom % 2, ($urandom % 4) != 0);
    check("R4", act_rise, exp_rise);
  endtask

  initial begin
    void'($urandom(32'd4711));
    repeat (3) @(posedge clk);
    @(negedge clk); #1;
    check("R10", cap_pulse, 0);
    check("R10", field_odd, 0);
    check("R10", line_ref, 0);
    rst_n = 1'b1;
    // lines before any field start: no strobe (R10)
    for (int l = 0; l < 30; l++)
      for (int c = 0; c < GAP + 2; c++) step(c == GAP + 1, 0, 0, 0);
    mode = 2'b00; field_scn(25, 0, 0, 0); field_scn(25, 1, 0, 0);
    field_scn(25, 0, 1, 0);
    mode = 2'b10; field_scn(25, 1, 0, 0); field_scn(25, 0, 1, 0);
    mode = 2'b11; field_scn(26, 1, 1, 0); field_scn(26, 0, 0, 0);
    mode = 2'b00; field_scn(25, 0, 0, 1);
    mode = 2'b10; field_scn(60, 1, 0, 0);   // R11 long field
    mode = 2'b01; osc_scn(1200); osc_scn(1200);
    mode = 2'b11; field_scn(25, 1, 0, 1);
    mode = 2'b01; field_scn(10, 1, 0, 0);   // hsync ignored in mode 01 (R7)
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule